// File: doc/BRIEF.md
# Interrupt Router Register Window

This block is the software-facing register file of an interrupt router. Software sees two 32-bit locations. The first is an 8-bit index register. The second is a data window, and a read or write through it goes to whatever the index register currently selects. The window reaches a small 4-bit router identifier, a read-only capability word, a read-only copy of the identifier, and the per-pin redirection table. Each table entry is 64 bits wide and is split across two consecutive indices.

The block keeps the redirection table and shows the whole table on a flat output bus, so that the delivery logic can read it. When a write changes the masking of a pin, the block raises a one-cycle notification that carries the pin number and the new mask value. The delivery logic can set an entry's remote-request status bit through a per-pin input. A software write to the low half of that entry clears the bit again.

Entry layout:
- vector: bits 7:0
- delivery mode: bits 10:8
- destination mode: bit 11
- remote-request status: bit 14
- trigger mode: bit 15 (1 = level)
- mask: bit 16
- destination: bits 63:56

Top module: `irqwin_top`

## Requirements
- R1: Only the low 8 bits of `addr` are decoded. Offset 0x00 is the index register and offset 0x10 is the data window. A read at any other offset returns zero, and a write there changes nothing. `rdData` is loaded on the clock edge that samples `rdEn` and holds its value until the next read.
- R2: A write to offset 0x00 stores `wrData[7:0]` as the index. A read of offset 0x00 returns the index in bits 7:0, with bits 31:8 zero.
- R3: Index 0x01 reads as the capability word. It has `NUM_PINS-1` in bits 23:16 and `VERSION_CODE` (default 0x11) in bits 7:0, so the default reads 0x00170011. Writes to this index leave it unchanged.
- R4: Index 0x00 holds the identifier in bits 27:24; all other bits read zero. A window write at this index loads `wrData[27:24]`. Index 0x02 reads the same word, and writes to index 0x02 are ignored.
- R5: An index from 0x10 upward selects table entry (index-0x10)>>1. An even index reaches entry bits 31:0 and an odd index reaches bits 63:32.
- R6: A window read returns 0xFFFFFFFF in two cases: the index is 0x03 to 0x0F, or the index selects an entry at or beyond `NUM_PINS`. Window writes at such indices change no state.
- R7: A write to the low half of an entry stores bit 14 (remote-request status) as 0, whatever the written data holds.
- R8: A write that flips an entry's mask bit (bit 16) makes `maskChg` high for exactly the following cycle. During that cycle `maskChgPin` carries the entry number and `maskChgVal` carries the new mask. A write that leaves the mask as it was gives no pulse.
- R9: After reset the index and identifier are zero, `maskChg` is low, and every entry is 0x0000_0000_0001_0000 (masked, all other fields zero).
- R10: A high level on `remoteIrrSet[i]` at a clock edge sets bit 14 of entry i. The bit then stays set until a low-half write clears it. If a low-half write to that entry happens on the same edge, the write wins.
- R11: `entryFlat[i*64 +: 64]` always equals entry i as it stands after the most recent clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write request for this cycle |
| rdEn | input | 1 | Read request for this cycle |
| addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, registered |
| remoteIrrSet | input | NUM_PINS | Per-pin set of the remote-request status bit |
| entryFlat | output | NUM_PINS*64 | Flattened redirection table |
| maskChg | output | 1 | One-cycle mask-change notification |
| maskChgPin | output | $clog2(NUM_PINS) | Entry whose mask changed |
| maskChgVal | output | 1 | New mask value |

## Verification
Three kinds of result have fixed timing:
- `rdData` is due one clock after the cycle in which `rdEn` is sampled.
- The mask-change pulse appears after the same edge that stores the write, and it lasts one cycle.
- Table contents on `entryFlat` change on the edge that samples the write or the set request.

The bench drives every request on a falling edge and holds it for one full cycle. It then checks results on the following falling edge, so each result is read half a period after the edge that produced it. A final idle cycle confirms that the notification has dropped.

// File: rtl/irqwin_pkg.sv
package irqwin_pkg;

  localparam logic [7:0] OFF_INDEX  = 8'h00;
  localparam logic [7:0] OFF_WINDOW = 8'h10;

  localparam logic [7:0] IDX_IDENT = 8'h00;
  localparam logic [7:0] IDX_CAPS  = 8'h01;
  localparam logic [7:0] IDX_IDCPY = 8'h02;
  localparam logic [7:0] IDX_TABLE = 8'h10;

  localparam int unsigned FLD_RIRR = 14;
  localparam int unsigned FLD_MASK = 16;
  localparam int unsigned ID_LSB   = 24;

  localparam logic [63:0] ENTRY_RESET = 64'(1) << FLD_MASK;

  typedef enum logic [2:0] {
    KIND_IDENT,
    KIND_CAPS,
    KIND_IDCPY,
    KIND_ENTRY,
    KIND_NONE
  } winKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       selRd;
    logic       winWr;
    logic       winRd;
    logic       idleRd;
    winKind_e   kind;
    logic       hiHalf;
    logic [6:0] entryNum;
    logic [7:0] selVal;
  } winStrobe_t;

endpackage

// File: rtl/irqwin_ctrl.sv
module irqwin_ctrl
  import irqwin_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrByte,
  output winStrobe_t        strb
);

  localparam logic [31:0] ENTRY_LIMIT = 32'(IDX_TABLE) + 32'(2 * NUM_PINS);

  logic [7:0] selReg;
  logic [7:0] off;
  logic [7:0] relIdx;
  logic       unusedAddrHi;
  logic       hitIndex;
  logic       hitWindow;
  winKind_e   kind;

  assign off          = addr[7:0];
  assign unusedAddrHi = ^addr[ADDR_W-1:8];
  assign hitIndex     = (off == OFF_INDEX);
  assign hitWindow    = (off == OFF_WINDOW);
  assign relIdx       = selReg - IDX_TABLE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= 8'h00;
    end else if (wrEn && hitIndex) begin
      selReg <= wrByte;
    end
  end

  always_comb begin
    if (selReg == IDX_IDENT) begin
      kind = KIND_IDENT;
    end else if (selReg == IDX_CAPS) begin
      kind = KIND_CAPS;
    end else if (selReg == IDX_IDCPY) begin
      kind = KIND_IDCPY;
    end else if (selReg >= IDX_TABLE && 32'(selReg) < ENTRY_LIMIT) begin
      kind = KIND_ENTRY;
    end else begin
      kind = KIND_NONE;
    end
  end

  always_comb begin
    strb.selRd    = rdEn && hitIndex;
    strb.winWr    = wrEn && hitWindow;
    strb.winRd    = rdEn && hitWindow;
    strb.idleRd   = rdEn && !hitIndex && !hitWindow;
    strb.kind     = kind;
    strb.hiHalf   = selReg[0];
    strb.entryNum = relIdx[7:1];
    strb.selVal   = selReg;
  end

endmodule

// File: rtl/irqwin_data.sv
module irqwin_data
  import irqwin_pkg::*;
#(
  parameter int unsigned NUM_PINS     = 24,
  parameter logic [7:0]  VERSION_CODE = 8'h11,
  localparam int unsigned PIN_W       = $clog2(NUM_PINS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  winStrobe_t               strb,
  input  logic [31:0]              wrData,
  input  logic [NUM_PINS-1:0]      remoteIrrSet,
  output logic [31:0]              rdData,
  output logic [NUM_PINS*64-1:0]   entryFlat,
  output logic                     maskChg,
  output logic [PIN_W-1:0]         maskChgPin,
  output logic                     maskChgVal
);

  localparam logic [31:0] CAPS_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION_CODE};

  logic [63:0]      tbl [NUM_PINS];
  logic [3:0]       identReg;
  logic [PIN_W-1:0] pinSel;
  logic             entryWr;
  logic             maskFlip;
  logic [63:0]      curEntry;
  logic [31:0]      winWord;
  logic [31:0]      rdNext;

  assign pinSel   = strb.entryNum[PIN_W-1:0];
  assign entryWr  = strb.winWr && (strb.kind == KIND_ENTRY);
  assign curEntry = tbl[pinSel];
  assign maskFlip = entryWr && !strb.hiHalf && (curEntry[FLD_MASK] != wrData[FLD_MASK]);

  // Table storage: set requests first, software writes override
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        tbl[i] <= ENTRY_RESET;
      end
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (remoteIrrSet[i]) begin
          tbl[i][FLD_RIRR] <= 1'b1;
        end
        if (entryWr && pinSel == PIN_W'(i)) begin
          if (strb.hiHalf) begin
            tbl[i][63:32] <= wrData;
          end else begin
            tbl[i][31:0]     <= wrData;
            tbl[i][FLD_RIRR] <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      identReg <= 4'h0;
    end else if (strb.winWr && strb.kind == KIND_IDENT) begin
      identReg <= wrData[ID_LSB+3:ID_LSB];
    end
  end

  always_comb begin
    case (strb.kind)
      KIND_IDENT, KIND_IDCPY: winWord = {4'h0, identReg, 24'h0};
      KIND_CAPS:              winWord = CAPS_WORD;
      KIND_ENTRY:             winWord = strb.hiHalf ? curEntry[63:32] : curEntry[31:0];
      default:                winWord = 32'hFFFF_FFFF;
    endcase
  end

  always_comb begin
    if (strb.selRd) begin
      rdNext = {24'h0, strb.selVal};
    end else if (strb.winRd) begin
      rdNext = winWord;
    end else begin
      rdNext = 32'h0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= 32'h0;
    end else if (strb.selRd || strb.winRd || strb.idleRd) begin
      rdData <= rdNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskChg    <= 1'b0;
      maskChgPin <= '0;
      maskChgVal <= 1'b0;
    end else begin
      maskChg <= maskFlip;
      if (maskFlip) begin
        maskChgPin <= pinSel;
        maskChgVal <= wrData[FLD_MASK];
      end
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_flat
    assign entryFlat[g*64 +: 64] = tbl[g];
  end

endmodule

// File: rtl/irqwin_top.sv
module irqwin_top
  import irqwin_pkg::*;
#(
  parameter int unsigned NUM_PINS     = 24,
  parameter int unsigned ADDR_W       = 12,
  parameter logic [7:0]  VERSION_CODE = 8'h11
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic                          rdEn,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [31:0]                   wrData,
  output logic [31:0]                   rdData,
  input  logic [NUM_PINS-1:0]           remoteIrrSet,
  output logic [NUM_PINS*64-1:0]        entryFlat,
  output logic                          maskChg,
  output logic [$clog2(NUM_PINS)-1:0]   maskChgPin,
  output logic                          maskChgVal
);

  winStrobe_t strb;

  irqwin_ctrl #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrByte (wrData[7:0]),
    .strb   (strb)
  );

  irqwin_data #(
    .NUM_PINS     (NUM_PINS),
    .VERSION_CODE (VERSION_CODE)
  ) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrData       (wrData),
    .remoteIrrSet (remoteIrrSet),
    .rdData       (rdData),
    .entryFlat    (entryFlat),
    .maskChg      (maskChg),
    .maskChgPin   (maskChgPin),
    .maskChgVal   (maskChgVal)
  );

endmodule

// File: rtl/irqwin_checker.sv
module irqwin_checker
  import irqwin_pkg::*;
#(
  parameter int unsigned NUM_PINS     = 24,
  parameter logic [7:0]  VERSION_CODE = 8'h11
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          wrEn,
  input logic                          rdEn,
  input logic [7:0]                    off,
  input logic [7:0]                    wrByte,
  input logic [31:0]                   rdData,
  input logic [NUM_PINS*64-1:0]        entryFlat,
  input logic                          maskChg,
  input logic [$clog2(NUM_PINS)-1:0]   maskChgPin,
  input logic                          maskChgVal
);

  localparam logic [31:0] LIMIT = 32'h10 + 32'(2 * NUM_PINS);

  logic [7:0] selShadow;
  logic [7:0] relIdx;
  logic       idxEntry;
  logic       idxBad;
  logic       rdWin;
  logic       wrWin;
  logic       rdOther;
  int         entryIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selShadow <= 8'h00;
    end else if (wrEn && off == 8'h00) begin
      selShadow <= wrByte;
    end
  end

  assign relIdx   = selShadow - 8'h10;
  assign entryIdx = int'(relIdx[7:1]);
  assign idxEntry = (selShadow >= 8'h10) && (32'(selShadow) < LIMIT);
  assign idxBad   = (selShadow > 8'h02) && !idxEntry;
  assign rdWin    = rdEn && (off == 8'h10);
  assign wrWin    = wrEn && (off == 8'h10);
  assign rdOther  = rdEn && (off != 8'h00) && (off != 8'h10);

  AST_OTHER_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdOther |=> (rdData == 32'h0)); // R1

  AST_INDEX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && off == 8'h00) |=> (rdData[31:8] == 24'h0)); // R2

  AST_CAPS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (rdWin && selShadow == 8'h01) |=>
      (rdData == {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION_CODE})); // R3

  AST_IDENT_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (rdWin && (selShadow == 8'h00 || selShadow == 8'h02)) |=>
      (rdData[23:0] == 24'h0 && rdData[31:28] == 4'h0)); // R4

  AST_BAD_INDEX_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (rdWin && idxBad) |=> (rdData == 32'hFFFF_FFFF)); // R6

  AST_LOW_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrWin && idxEntry && !selShadow[0]) |=>
      (entryFlat[$past(entryIdx) * 64 + FLD_RIRR] == 1'b0)); // R7

  AST_NOTIFY_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    maskChg |-> $past(wrWin)); // R8

  AST_NOTIFY_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    maskChg |-> (entryFlat[int'(maskChgPin) * 64 + FLD_MASK] == maskChgVal)); // R8

endmodule

bind irqwin_top irqwin_checker #(
  .NUM_PINS     (NUM_PINS),
  .VERSION_CODE (VERSION_CODE)
) u_irqwin_checker (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .off        (addr[7:0]),
  .wrByte     (wrData[7:0]),
  .rdData     (rdData),
  .entryFlat  (entryFlat),
  .maskChg    (maskChg),
  .maskChgPin (maskChgPin),
  .maskChgVal (maskChgVal)
);

// File: tb/irqwin_top_bench.sv
module irqwin_top_bench;

  localparam int unsigned NUM_PINS = 24;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned PIN_W    = $clog2(NUM_PINS);

  typedef struct packed {
    logic        isRd;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] e;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 46;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 12'h000, 32'h0000_01FF, 32'h0,          8'd2},  // R2 wide data
    '{1'b1, 12'h000, 32'h0,         32'h0000_00FF,  8'd2},  // R2
    '{1'b0, 12'h000, 32'h0000_0001, 32'h0,          8'd3},
    '{1'b1, 12'h010, 32'h0,         32'h0017_0011,  8'd3},  // R3
    '{1'b0, 12'h010, 32'hFFFF_FFFF, 32'h0,          8'd3},
    '{1'b1, 12'h010, 32'h0,         32'h0017_0011,  8'd3},  // R3 write ignored
    '{1'b0, 12'h000, 32'h0000_0000, 32'h0,          8'd4},
    '{1'b0, 12'h010, 32'hA500_0000, 32'h0,          8'd4},
    '{1'b1, 12'h010, 32'h0,         32'h0500_0000,  8'd4},  // R4
    '{1'b0, 12'h000, 32'h0000_0002, 32'h0,          8'd4},
    '{1'b1, 12'h010, 32'h0,         32'h0500_0000,  8'd4},  // R4 copy
    '{1'b0, 12'h010, 32'h0F00_0000, 32'h0,          8'd4},
    '{1'b1, 12'h010, 32'h0,         32'h0500_0000,  8'd4},  // R4 copy read-only
    '{1'b0, 12'h000, 32'h0000_0000, 32'h0,          8'd4},
    '{1'b1, 12'h010, 32'h0,         32'h0500_0000,  8'd4},  // R4
    '{1'b0, 12'h000, 32'h0000_0010, 32'h0,          8'd9},
    '{1'b1, 12'h010, 32'h0,         32'h0001_0000,  8'd9},  // R9 entry0 low
    '{1'b0, 12'h010, 32'h0000_C0A5, 32'h0,          8'd7},
    '{1'b1, 12'h010, 32'h0,         32'h0000_80A5,  8'd7},  // R7
    '{1'b0, 12'h000, 32'h0000_0011, 32'h0,          8'd9},
    '{1'b1, 12'h010, 32'h0,         32'h0000_0000,  8'd9},  // R9 entry0 high
    '{1'b0, 12'h010, 32'h7E00_0000, 32'h0,          8'd5},
    '{1'b1, 12'h010, 32'h0,         32'h7E00_0000,  8'd5},  // R5
    '{1'b0, 12'h000, 32'h0000_0010, 32'h0,          8'd5},
    '{1'b1, 12'h010, 32'h0,         32'h0000_80A5,  8'd5},  // R5 low kept
    '{1'b0, 12'h000, 32'h0000_003F, 32'h0,          8'd5},
    '{1'b0, 12'h010, 32'h1234_5678, 32'h0,          8'd5},
    '{1'b1, 12'h010, 32'h0,         32'h1234_5678,  8'd5},  // R5 last entry high
    '{1'b0, 12'h000, 32'h0000_003E, 32'h0,          8'd5},
    '{1'b1, 12'h010, 32'h0,         32'h0001_0000,  8'd5},  // R5 last entry low
    '{1'b0, 12'h000, 32'h0000_0040, 32'h0,          8'd6},
    '{1'b1, 12'h010, 32'h0,         32'hFFFF_FFFF,  8'd6},  // R6 past table
    '{1'b0, 12'h010, 32'h0000_0000, 32'h0,          8'd6},
    '{1'b1, 12'h010, 32'h0,         32'hFFFF_FFFF,  8'd6},  // R6
    '{1'b0, 12'h000, 32'h0000_0005, 32'h0,          8'd6},
    '{1'b1, 12'h010, 32'h0,         32'hFFFF_FFFF,  8'd6},  // R6 gap index
    '{1'b0, 12'h000, 32'h0000_000F, 32'h0,          8'd6},
    '{1'b1, 12'h010, 32'h0,         32'hFFFF_FFFF,  8'd6},  // R6 gap index
    '{1'b1, 12'h020, 32'h0,         32'h0000_0000,  8'd1},  // R1 other offset
    '{1'b0, 12'h020, 32'h1234_5678, 32'h0,          8'd1},
    '{1'b1, 12'h000, 32'h0,         32'h0000_000F,  8'd1},  // R1 write ignored
    '{1'b1, 12'h110, 32'h0,         32'hFFFF_FFFF,  8'd1},  // R1 high bits ignored
    '{1'b0, 12'h100, 32'h0000_00AB, 32'h0,          8'd1},
    '{1'b1, 12'h000, 32'h0,         32'h0000_00AB,  8'd1},  // R1 alias
    '{1'b1, 12'h004, 32'h0,         32'h0000_0000,  8'd1},  // R1
    '{1'b1, 12'h01C, 32'h0,         32'h0000_0000,  8'd1}   // R1
  };

  logic                        clk = 1'b0;
  logic                        rstN = 1'b0;
  logic                        wrEn = 1'b0;
  logic                        rdEn = 1'b0;
  logic [ADDR_W-1:0]           addr = '0;
  logic [31:0]                 wrData = '0;
  logic [31:0]                 rdData;
  logic [NUM_PINS-1:0]         remoteIrrSet = '0;
  logic [NUM_PINS*64-1:0]      entryFlat;
  logic                        maskChg;
  logic [PIN_W-1:0]            maskChgPin;
  logic                        maskChgVal;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  irqwin_top #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
  ) u_irqwin_top (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .rdEn         (rdEn),
    .addr         (addr),
    .wrData       (wrData),
    .rdData       (rdData),
    .remoteIrrSet (remoteIrrSet),
    .entryFlat    (entryFlat),
    .maskChg      (maskChg),
    .maskChgPin   (maskChgPin),
    .maskChgVal   (maskChgVal)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    check(tag, 64'(rdData), 64'(e));
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    applyReset();

    // R9 reset state at the ports, R11 mirror
    check("R9 rdData", 64'(rdData), 64'h0);
    check("R9 maskChg", 64'(maskChg), 64'h0);
    for (int i = 0; i < NUM_PINS; i++) begin
      check("R11 reset entry", entryFlat[i*64 +: 64], 64'h0000_0000_0001_0000);
    end
    doRead(12'h000, 32'h0, "R9 index");
    doRead(12'h010, 32'h0, "R9 identifier");

    // Vector table walk
    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].isRd) begin
        doRead(VECS[v].a, VECS[v].e, $sformatf("R%0d vec%0d", VECS[v].req, v));
      end else begin
        doWrite(VECS[v].a, VECS[v].d);
      end
    end

    // R8 mask change notification on entry 1
    doWrite(12'h000, 32'h12);
    check("R8 no pulse on index write", 64'(maskChg), 64'h0);
    doWrite(12'h010, 32'h0000_0033);
    check("R8 pulse", 64'(maskChg), 64'h1);
    check("R8 pin", 64'(maskChgPin), 64'h1);
    check("R8 value", 64'(maskChgVal), 64'h0);
    doWrite(12'h010, 32'h0000_0044);
    check("R8 unchanged mask", 64'(maskChg), 64'h0);
    doWrite(12'h000, 32'h13);
    doWrite(12'h010, 32'hFFFF_FFFF);
    check("R8 high half", 64'(maskChg), 64'h0);
    doWrite(12'h000, 32'h12);
    doWrite(12'h010, 32'h0001_0000);
    check("R8 remask pulse", 64'(maskChg), 64'h1);
    check("R8 remask value", 64'(maskChgVal), 64'h1);
    @(negedge clk);
    check("R8 single cycle", 64'(maskChg), 64'h0);
    check("R11 entry1", entryFlat[64 +: 64], 64'hFFFF_FFFF_0001_0000);

    // R10 remote-request set, then R7 clear by low write (entry 3)
    @(negedge clk);
    remoteIrrSet = NUM_PINS'(1) << 3;
    @(negedge clk);
    remoteIrrSet = '0;
    check("R11 rirr bit", 64'(entryFlat[3*64 + 14]), 64'h1);
    doWrite(12'h000, 32'h16);
    doRead(12'h010, 32'h0001_4000, "R10 set visible");
    doRead(12'h010, 32'h0001_4000, "R10 held");
    doWrite(12'h010, 32'h0001_4000);
    doRead(12'h010, 32'h0001_0000, "R7 cleared");
    check("R11 rirr cleared", 64'(entryFlat[3*64 + 14]), 64'h0);

    // R10 same-edge collision, write wins
    @(negedge clk);
    remoteIrrSet = NUM_PINS'(1) << 3;
    wrEn = 1'b1; addr = 12'h010; wrData = 32'h0001_0007;
    @(negedge clk);
    remoteIrrSet = '0;
    wrEn = 1'b0;
    doRead(12'h010, 32'h0001_0007, "R10 write wins");

    // R9 reset in mid-run
    applyReset();
    doRead(12'h000, 32'h0, "R9 index after reset");
    doRead(12'h010, 32'h0, "R9 identifier after reset");
    doWrite(12'h000, 32'h12);
    doRead(12'h010, 32'h0001_0000, "R9 entry after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule